// File: doc/BRIEF.md
# Region Close Sequencer

This block tracks the lifetime of one cache's synchronization-free region and carries out the work needed to close it. It holds a flag that says a region is open, a per-line "handed to a peer" bit with a cache-wide summary of those bits, and per-line byte masks of what the local thread has read and written during the region. The core opens a region with a begin command and closes it with an end command. While the region is open, local accesses set bits in the byte masks, and lines given to other caches are marked.

On close there are two paths. If no line was handed to a peer during the region, all region state is wiped at the next clock edge and the core is never stalled. Otherwise the core is stalled while the block walks the marked lines from the lowest index upward. For each one it emits a record holding the line index and that line's read and write byte masks over a valid/ready port. It then waits for a fixed number of acknowledgments from peers before wiping the state and releasing the core. This lets the peers retract the remote-access bits they had copied from this cache before any new region can start.

Top module: `region_end_seq`

## Requirements
- R1: After reset the region flag, stall and message valid are low. A begin command while no region is open raises the region flag at the next edge without stalling.
- R2: A begin command while a region is open, including while it is closing, changes no state and pulses `nest_err` high for exactly the following cycle.
- R3: While a region is open and not closing, an access with `acc_wr`=1 ORs `acc_mask` into the write mask of line `acc_idx`, and one with `acc_wr`=0 ORs it into the read mask. An access while no region is open leaves the masks unchanged, as seen on the lookup port.
- R4: A supply event while a region is open and not closing sets that line's handed bit, shown on `lk_sup`, and the cache-wide summary. A supply event while no region is open is ignored, so a later close takes the fast path.
- R5: An end command with an open region and a clear summary lowers the region flag at the next edge and clears every line's masks and handed bit. `stall` stays low throughout.
- R6: An end command with an open region and a set summary raises `stall` from the next edge. Records are then offered for every handed line in ascending index order, one per accepted handshake. Each record carries `msg_idx` and that line's read and write masks.
- R7: An offered record whose `msg_ready` is low stays offered with unchanged index and masks in the next cycle.
- R8: The closing region keeps the region flag and `stall` high until the first edge at which no record is left to offer and the acknowledgments counted since the end command reach ACK_COUNT. This count includes an acknowledgment presented on that edge. At that edge everything is cleared and `stall` falls.
- R9: An end command with no open region has no effect and raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| begin_cmd | input | 1 | Open a region |
| end_cmd | input | 1 | Close the open region |
| acc_vld | input | 1 | Local access event |
| acc_wr | input | 1 | Access is a write (1) or read (0) |
| acc_idx | input | IDX_W | Line index of the access |
| acc_mask | input | LINE_BYTES | Bytes touched by the access |
| sup_vld | input | 1 | Line was handed to a peer |
| sup_idx | input | IDX_W | Index of the handed line |
| ack_in | input | 1 | One acknowledgment from a peer |
| msg_ready | input | 1 | Message port can accept a record |
| lk_idx | input | IDX_W | Lookup line index |
| in_region | output | 1 | A region is open |
| stall | output | 1 | Core must hold while the region closes |
| nest_err | output | 1 | Begin arrived inside an open region |
| msg_valid | output | 1 | A record is offered |
| msg_idx | output | IDX_W | Line index of the record |
| msg_rd | output | LINE_BYTES | Read mask of the record's line |
| msg_wr | output | LINE_BYTES | Write mask of the record's line |
| lk_rd | output | LINE_BYTES | Read mask of line `lk_idx` |
| lk_wr | output | LINE_BYTES | Write mask of line `lk_idx` |
| lk_sup | output | 1 | Handed bit of line `lk_idx` |

## Verification
The assertions check the following properties on every cycle:
- the one-cycle effects of begin, nested begin and fast close;
- that a supply event marks its line and the summary;
- that an offered record holds steady under backpressure;
- that stall never stands without an open region;
- that stall only falls together with the region flag.

Only the bench scenarios can show three further behaviours:
- that the walk visits exactly the handed lines, in ascending order, with masks matching the accesses made;
- that the release edge matches the acknowledgment count under random ready and acknowledgment timing;
- that all masks read back as zero once the region closes.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WALK = 2'd1,
      ST_WAIT = 2'd2
   } seq_st_t;
endpackage

// File: rtl/rseq_pick.sv
module rseq_pick #(
   parameter int N    = 8,
   parameter int IW   = 3
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  gnt
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = IW'(i);
            any = 1'b1;
         end
      end
      gnt = any ? ({{(N-1){1'b0}}, 1'b1} << idx) : '0;
   end
endmodule

// File: rtl/rseq_lines.sv
module rseq_lines #(
   parameter int NL = 8,
   parameter int LB = 8,
   parameter int IW = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_en,
   input  logic                  acc_wr,
   input  logic [IW-1:0]         acc_idx,
   input  logic [LB-1:0]         acc_mask,
   input  logic                  sup_en,
   input  logic [IW-1:0]         sup_idx,
   input  logic                  clr_all,
   input  logic                  pend_load,
   input  logic [NL-1:0]         pend_drop,
   output logic [NL-1:0][LB-1:0] lrd,
   output logic [NL-1:0][LB-1:0] lwr,
   output logic [NL-1:0]         sup,
   output logic [NL-1:0]         pend,
   output logic                  csup
);
   logic csup_q;

   for (genvar g = 0; g < NL; g++) begin : g_line
      logic [LB-1:0] rd_q, wr_q;
      logic          sup_q, pend_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr_all) begin
            rd_q   <= '0;
            wr_q   <= '0;
            sup_q  <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            if (acc_en && acc_idx == IW'(g)) begin
               if (acc_wr) wr_q <= wr_q | acc_mask;
               else        rd_q <= rd_q | acc_mask;
            end
            if (sup_en && sup_idx == IW'(g)) sup_q <= 1'b1;
            if (pend_load)         pend_q <= sup_q;
            else if (pend_drop[g]) pend_q <= 1'b0;
         end
      end
      assign lrd[g]  = rd_q;
      assign lwr[g]  = wr_q;
      assign sup[g]  = sup_q;
      assign pend[g] = pend_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_all) csup_q <= 1'b0;
      else if (sup_en)       csup_q <= 1'b1;
   end
   assign csup = csup_q;

   // R4: a supply event marks its line and the cache-wide summary
   assert_supply_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_en && !clr_all) |=> (csup && sup[$past(sup_idx)]));
endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
   import rseq_pkg::*;
#(
   parameter int ACK_COUNT = 3,
   localparam int CNT_W = (ACK_COUNT < 1) ? 1 : $clog2(ACK_COUNT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic begin_cmd,
   input  logic end_cmd,
   input  logic csup,
   input  logic pend_any,
   input  logic ack_in,
   output logic in_region,
   output logic open_win,
   output logic walking,
   output logic stall,
   output logic nest_err,
   output logic clr_all,
   output logic pend_load
);
   seq_st_t          st_q, st_d;
   logic             in_q, err_q;
   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             clr_fast, start_walk, drained, done;

   assign open_win   = in_q && (st_q == ST_IDLE);
   assign clr_fast   = end_cmd && open_win && !csup;
   assign start_walk = end_cmd && open_win && csup;
   assign drained    = ((st_q == ST_WALK) && !pend_any) || (st_q == ST_WAIT);
   assign cnt_nxt    = (cnt_q >= CNT_W'(ACK_COUNT)) ? cnt_q : cnt_q + CNT_W'(ack_in);
   assign done       = drained && (cnt_nxt >= CNT_W'(ACK_COUNT));
   assign clr_all    = clr_fast || done;
   assign pend_load  = start_walk;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (start_walk) st_d = ST_WALK;
         ST_WALK: if (!pend_any) st_d = done ? ST_IDLE : ST_WAIT;
         ST_WAIT: if (done) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         in_q  <= 1'b0;
         err_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         err_q <= begin_cmd && in_q;
         if (begin_cmd && !in_q) in_q <= 1'b1;
         else if (clr_all)       in_q <= 1'b0;
         if (start_walk)              cnt_q <= '0;
         else if (st_q != ST_IDLE)    cnt_q <= cnt_nxt;
      end
   end

   assign in_region = in_q;
   assign walking   = (st_q == ST_WALK);
   assign stall     = (st_q != ST_IDLE);
   assign nest_err  = err_q;

   assert_begin_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (begin_cmd && !in_region) |=> (in_region && !stall));
   assert_nested_begin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (begin_cmd && in_region) |=> (nest_err && in_region));
   assert_fast_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (end_cmd && open_win && !csup) |=> (!in_region && !stall));
   assert_stall_in_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> in_region);
   assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> !in_region);
   assert_stray_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (end_cmd && !in_region && !stall) |=> !stall);
endmodule

// File: rtl/region_end_seq.sv
module region_end_seq #(
   parameter int NUM_LINES  = 8,
   parameter int LINE_BYTES = 8,
   parameter int ACK_COUNT  = 3,
   localparam int IDX_W = $clog2(NUM_LINES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  begin_cmd,
   input  logic                  end_cmd,
   input  logic                  acc_vld,
   input  logic                  acc_wr,
   input  logic [IDX_W-1:0]      acc_idx,
   input  logic [LINE_BYTES-1:0] acc_mask,
   input  logic                  sup_vld,
   input  logic [IDX_W-1:0]      sup_idx,
   input  logic                  ack_in,
   input  logic                  msg_ready,
   input  logic [IDX_W-1:0]      lk_idx,
   output logic                  in_region,
   output logic                  stall,
   output logic                  nest_err,
   output logic                  msg_valid,
   output logic [IDX_W-1:0]      msg_idx,
   output logic [LINE_BYTES-1:0] msg_rd,
   output logic [LINE_BYTES-1:0] msg_wr,
   output logic [LINE_BYTES-1:0] lk_rd,
   output logic [LINE_BYTES-1:0] lk_wr,
   output logic                  lk_sup
);
   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (LINE_BYTES < 1) begin : g_bad_bytes
      $error("LINE_BYTES must be at least 1");
   end
   if (ACK_COUNT < 0) begin : g_bad_acks
      $error("ACK_COUNT must not be negative");
   end

   logic [NUM_LINES-1:0][LINE_BYTES-1:0] lrd, lwr;
   logic [NUM_LINES-1:0] sup, pend, gnt, pend_drop;
   logic csup, pend_any, open_win, walking, clr_all, pend_load, hs;

   rseq_ctrl #(.ACK_COUNT(ACK_COUNT)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .begin_cmd(begin_cmd), .end_cmd(end_cmd),
      .csup(csup), .pend_any(pend_any), .ack_in(ack_in),
      .in_region(in_region), .open_win(open_win), .walking(walking),
      .stall(stall), .nest_err(nest_err), .clr_all(clr_all),
      .pend_load(pend_load)
   );

   rseq_lines #(.NL(NUM_LINES), .LB(LINE_BYTES), .IW(IDX_W)) lines_i (
      .clk(clk), .rst_n(rst_n),
      .acc_en(acc_vld && open_win), .acc_wr(acc_wr), .acc_idx(acc_idx),
      .acc_mask(acc_mask), .sup_en(sup_vld && open_win), .sup_idx(sup_idx),
      .clr_all(clr_all), .pend_load(pend_load), .pend_drop(pend_drop),
      .lrd(lrd), .lwr(lwr), .sup(sup), .pend(pend), .csup(csup)
   );

   rseq_pick #(.N(NUM_LINES), .IW(IDX_W)) pick_i (
      .req(pend), .any(pend_any), .idx(msg_idx), .gnt(gnt)
   );

   assign msg_valid = walking && pend_any;
   assign hs        = msg_valid && msg_ready;
   assign pend_drop = hs ? gnt : '0;
   assign msg_rd    = lrd[msg_idx];
   assign msg_wr    = lwr[msg_idx];
   assign lk_rd     = lrd[lk_idx];
   assign lk_wr     = lwr[lk_idx];
   assign lk_sup    = sup[lk_idx];

   assert_msg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=>
         (msg_valid && $stable(msg_idx) && $stable(msg_rd) && $stable(msg_wr)));
   assert_walk_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> stall);
endmodule

// File: tb/region_end_seq_tb_top.sv
`timescale 1ns/100ps
module region_end_seq_tb_top;
   localparam int NL = 8;
   localparam int LB = 8;
   localparam int NA = 3;
   localparam int IW = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, begin_cmd, end_cmd, acc_vld, acc_wr, sup_vld, ack_in, msg_ready;
   logic [IW-1:0] acc_idx, sup_idx, lk_idx, msg_idx;
   logic [LB-1:0] acc_mask, msg_rd, msg_wr, lk_rd, lk_wr;
   logic in_region, stall, nest_err, msg_valid, lk_sup;

   region_end_seq #(.NUM_LINES(NL), .LINE_BYTES(LB), .ACK_COUNT(NA)) dut_i (
      .clk(clk), .rst_n(rst_n), .begin_cmd(begin_cmd), .end_cmd(end_cmd),
      .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_idx(acc_idx), .acc_mask(acc_mask),
      .sup_vld(sup_vld), .sup_idx(sup_idx), .ack_in(ack_in), .msg_ready(msg_ready),
      .lk_idx(lk_idx), .in_region(in_region), .stall(stall), .nest_err(nest_err),
      .msg_valid(msg_valid), .msg_idx(msg_idx), .msg_rd(msg_rd), .msg_wr(msg_wr),
      .lk_rd(lk_rd), .lk_wr(lk_wr), .lk_sup(lk_sup)
   );

   int checks = 0;
   int fails  = 0;
   logic [LB-1:0] m_rd [NL];
   logic [LB-1:0] m_wr [NL];
   logic          m_sup [NL];
   logic          m_csup, m_in;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic clear_model();
      for (int i = 0; i < NL; i++) begin
         m_rd[i] = '0; m_wr[i] = '0; m_sup[i] = 1'b0;
      end
      m_csup = 1'b0;
      m_in   = 1'b0;
   endtask

   task automatic check_lookup(input string tag);
      for (int i = 0; i < NL; i++) begin
         lk_idx = IW'(i);
         #0.2;
         chk({tag, " lookup rd"}, 32'(lk_rd), 32'(m_rd[i]));
         chk({tag, " lookup wr"}, 32'(lk_wr), 32'(m_wr[i]));
         chk({tag, " lookup sup"}, 32'(lk_sup), 32'(m_sup[i]));
      end
   endtask

   task automatic do_begin();
      begin_cmd = 1'b1;
      cyc();
      begin_cmd = 1'b0;
      m_in = 1'b1;
   endtask

   task automatic do_access(input logic wr, input int idx, input logic [LB-1:0] mask);
      acc_vld = 1'b1; acc_wr = wr; acc_idx = IW'(idx); acc_mask = mask;
      cyc();
      acc_vld = 1'b0;
      if (m_in) begin
         if (wr) m_wr[idx] = m_wr[idx] | mask;
         else    m_rd[idx] = m_rd[idx] | mask;
      end
   endtask

   task automatic do_supply(input int idx);
      sup_vld = 1'b1; sup_idx = IW'(idx);
      cyc();
      sup_vld = 1'b0;
      if (m_in) begin
         m_sup[idx] = 1'b1;
         m_csup = 1'b1;
      end
   endtask

   function automatic int lowest(input logic p [NL]);
      for (int i = 0; i < NL; i++) if (p[i]) return i;
      return -1;
   endfunction

   task automatic end_region(input int rdy_pct, input int ack_pct);
      logic p [NL];
      int cnt, held, e;
      logic done, rdy, ack, hs, any;
      end_cmd = 1'b1;
      cyc();
      end_cmd = 1'b0;
      if (!m_in) begin
         chk("R9 stray end stall", 32'(stall), 32'd0);
         return;
      end
      if (!m_csup) begin
         chk("R5 fast close region", 32'(in_region), 32'd0);
         chk("R5 fast close stall", 32'(stall), 32'd0);
         clear_model();
         check_lookup("R5");
         return;
      end
      chk("R6 stall after end", 32'(stall), 32'd1);
      for (int i = 0; i < NL; i++) p[i] = m_sup[i];
      cnt = 0; held = -1; done = 1'b0;
      for (int k = 0; k < 300 && !done; k++) begin
         rdy = ($urandom % 100) < rdy_pct;
         ack = ($urandom % 100) < ack_pct;
         msg_ready = rdy; ack_in = ack;
         #0.5;
         e = lowest(p);
         any = (e >= 0);
         chk("R6 msg_valid", 32'(msg_valid), 32'(any));
         if (any) begin
            chk("R6 record index", 32'(msg_idx), 32'(e));
            chk("R6 record rd", 32'(msg_rd), 32'(m_rd[e]));
            chk("R6 record wr", 32'(msg_wr), 32'(m_wr[e]));
            if (held >= 0) chk("R7 held record", 32'(msg_idx), 32'(held));
         end
         hs = any && rdy;
         held = (any && !rdy) ? e : -1;
         @(posedge clk);
         #1;
         if (!any) begin
            if (cnt + int'(ack) >= NA) done = 1'b1;
            else cnt = cnt + int'(ack);
         end else begin
            if (hs) p[e] = 1'b0;
            if (cnt < NA) cnt = cnt + int'(ack);
         end
         chk("R8 stall", 32'(stall), 32'(!done));
         chk("R8 region flag", 32'(in_region), 32'(!done));
      end
      msg_ready = 1'b0; ack_in = 1'b0;
      chk("R8 walk finished", 32'(done), 32'd1);
      clear_model();
      check_lookup("R8");
      chk("R8 no record after close", 32'(msg_valid), 32'd0);
   endtask

   task automatic random_body(input int n);
      for (int k = 0; k < n; k++) begin
         int r;
         r = int'($urandom % 3);
         if (r == 0)      do_access(1'b0, int'($urandom % NL), LB'($urandom));
         else if (r == 1) do_access(1'b1, int'($urandom % NL), LB'($urandom));
         else             do_supply(int'($urandom % NL));
      end
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; begin_cmd = 0; end_cmd = 0; acc_vld = 0; acc_wr = 0;
      acc_idx = '0; acc_mask = '0; sup_vld = 0; sup_idx = '0; ack_in = 0;
      msg_ready = 0; lk_idx = '0;
      clear_model();
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      chk("R1 reset region", 32'(in_region), 32'd0);
      chk("R1 reset stall", 32'(stall), 32'd0);
      chk("R1 reset msg_valid", 32'(msg_valid), 32'd0);

      // R9: close with no open region
      end_region(100, 100);

      // R3/R4: access and supply outside a region are ignored
      do_access(1'b1, 2, 8'hff);
      do_supply(5);
      check_lookup("R3 outside");

      // R1: open region
      do_begin();
      chk("R1 region opened", 32'(in_region), 32'd1);
      chk("R1 no stall on begin", 32'(stall), 32'd0);
      // R2: nested begin
      begin_cmd = 1'b1; cyc(); begin_cmd = 1'b0;
      chk("R2 nest_err pulse", 32'(nest_err), 32'd1);
      chk("R2 region kept", 32'(in_region), 32'd1);
      cyc();
      chk("R2 nest_err one cycle", 32'(nest_err), 32'd0);

      // R3: accesses inside region, fast close (R4 supply before open ignored)
      random_body(0);
      for (int k = 0; k < 10; k++)
         do_access(logic'($urandom % 2), int'($urandom % NL), LB'($urandom));
      check_lookup("R3 inside");
      end_region(100, 100);

      // R4: supply sets marks, then walk with eager ready and acks
      do_begin();
      do_access(1'b0, 6, 8'h0f);
      do_supply(6);
      do_supply(1);
      check_lookup("R4 marks");
      end_region(100, 100);

      // R6/R7/R8: random rounds with backpressure and late acks
      for (int r = 0; r < 12; r++) begin
         do_begin();
         random_body(14);
         check_lookup("R3 random");
         end_region(20 + 10 * r, 15 + 5 * r);
      end

      // R8: every line handed, slow acks
      do_begin();
      for (int i = 0; i < NL; i++) do_supply(i);
      end_region(50, 5);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule